// File: doc/BRIEF.md
# Persist Ordering Interval Checker

The block watches a trace of persistent-memory events and judges, at run time, whether ordering and durability guarantees hold for the writes it has seen. Each event is a store to an address, a writeback of an address, or a fence. For every tracked address the block records the window in which that store could reach persistence. The window opens at the store. It closes at the first fence that follows a writeback of the same address.

Time is kept as an epoch count that advances once per fence. A window opens at the current epoch and closes at the epoch of its closing fence, which is the count before that fence advances it. An ordering query asks whether store A is guaranteed to persist before store B. It passes only when A's window has closed at an epoch strictly smaller than the epoch at which B's window opened; any overlap is reported as a possible reordering. A durability query asks whether A has already been both written back and fenced.

The block never enumerates reorderings. It answers each query from the one trace it has observed, one cycle after the query is accepted.

Top module: `persist_order_checker`

## Requirements
- R1: After reset, `r_valid` and `overflow` are 0, `q_ready` is 1, and no address is tracked, so any query reports `r_miss`=1.
- R2: A store (`ev_op`=0) opens a window for its address at the current epoch. A durability query (`q_kind`=1) on that address fails while the store still lacks a writeback followed by a fence.
- R3: A store to a new address while all DEPTH entries are in use sets `overflow`, which stays 1 until reset. The store is dropped, so a query on that address reports a miss.
- R4: Each fence (`ev_op`=2) advances the epoch by one. An ordering query (`q_kind`=0) passes when A closed at an earlier epoch than the one at which B opened, for example when B is stored after A's closing fence.
- R5: An ordering query fails with `r_violation`=1 when A is not yet closed, or when B opened in the same epoch in which A closed.
- R6: A fence closes only the windows that have seen a writeback (`ev_op`=1) since their store. A fence with no earlier writeback leaves the window open. After a writeback and then a fence, a durability query passes.
- R7: A store to an address that is already tracked reuses its entry and reopens its window, so a durability query fails again. This store takes no new entry and cannot cause an overflow.
- R8: A writeback to an address that is not tracked has no effect. A later store to that address followed by a fence, with no writeback in between, leaves the store not durable.
- R9: When an operand address is not tracked, the result has `r_miss`=1, `r_pass`=0 and `r_violation`=0. A durability query looks only at A. In every result exactly one of `r_pass`, `r_violation` and `r_miss` is 1.
- R10: `q_ready` is always 1. A result is valid (`r_valid`=1) in the cycle after each cycle with `q_valid`=1, and only then. A query sees the table as it stood before any event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_op | input | 2 | Event kind: 0 store, 1 writeback, 2 fence, 3 ignored |
| ev_addr | input | ADDR_W | Event address (not used for a fence) |
| q_valid | input | 1 | Query request |
| q_ready | output | 1 | Query accepted (always 1) |
| q_kind | input | 1 | 0 ordering A before B, 1 durability of A |
| q_addr_a | input | ADDR_W | Address of store A |
| q_addr_b | input | ADDR_W | Address of store B (ordering only) |
| r_valid | output | 1 | Result valid |
| r_pass | output | 1 | Guarantee holds |
| r_violation | output | 1 | Guarantee broken for tracked stores |
| r_miss | output | 1 | An operand address is not tracked |
| overflow | output | 1 | Sticky: a store found the table full |

## Verification
A stimulus table drives one trace through a sequence of cases. In one, a store, its writeback and its fence come before the second store, which gives disjoint windows. In another, the second store lands before the first one's closing fence, which gives windows sharing an epoch. A third case has a fence with no writeback, and a fourth has a writeback to an address that was never stored. Together these separate a correct strict epoch comparison from an off-by-one or a non-strict one, and a close that really needs a writeback from one that fires on any fence. Directed cases then fill the table, rewrite a tracked address while the table is full, overflow it, check the one-cycle result timing and reset in the middle of a run. These cases separate reuse of an entry from allocation of a new one, and show that reset clears the state.

// File: rtl/pochk_pkg.sv
package pochk_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_WBACK = 2'd1,
    OP_FENCE = 2'd2,
    OP_NONE  = 2'd3
  } ev_op_e;

  typedef enum logic {
    Q_ORDER   = 1'b0,
    Q_DURABLE = 1'b1
  } q_kind_e;
endpackage

// File: rtl/pochk_epoch.sv
module pochk_epoch #(
  parameter int EPOCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fence_i,
  output logic [EPOCH_W-1:0] epoch_o
);
  logic [EPOCH_W-1:0] epoch_q, epoch_d;

  always_comb begin
    epoch_d = epoch_q;
    if (fence_i) epoch_d = epoch_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       epoch_q <= '0;
    else if (fence_i) epoch_q <= epoch_d;
  end

  assign epoch_o = epoch_q;

  // R4: time only moves on a fence
  assert_epoch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fence_i |=> $stable(epoch_o));
endmodule

// File: rtl/pochk_match.sv
module pochk_match #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DEPTH-1:0]             used_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] tags_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = used_i[i] && (tags_i[i] == addr_i);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i] && !hit_o) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  // R7: a rewrite reuses its entry, so no address is held twice
  assert_unique_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/pochk_table.sv
module pochk_table
  import pochk_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 32,
  parameter int EPOCH_W = 16,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ev_valid_i,
  input  ev_op_e                        ev_op_i,
  input  logic [ADDR_W-1:0]             ev_addr_i,
  input  logic [EPOCH_W-1:0]            epoch_i,
  output logic [DEPTH-1:0]              used_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]  tags_o,
  output logic [DEPTH-1:0]              closed_o,
  output logic [DEPTH-1:0][EPOCH_W-1:0] open_ep_o,
  output logic [DEPTH-1:0][EPOCH_W-1:0] close_ep_o,
  output logic                          overflow_o
);
  logic             is_wr, is_wb, is_fn;
  logic             ev_hit;
  logic [IDX_W-1:0] ev_idx;
  logic             have_free;
  logic [IDX_W-1:0] free_idx;
  logic             ovf_q, ovf_d;

  assign is_wr = ev_valid_i && (ev_op_i == OP_WRITE);
  assign is_wb = ev_valid_i && (ev_op_i == OP_WBACK);
  assign is_fn = ev_valid_i && (ev_op_i == OP_FENCE);

  pochk_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_ev_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .used_i (used_o),
    .tags_i (tags_o),
    .addr_i (ev_addr_i),
    .hit_o  (ev_hit),
    .idx_o  (ev_idx)
  );

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!used_o[i] && !have_free) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic               used_q, used_d;
    logic               flushed_q, flushed_d;
    logic               closed_q, closed_d;
    logic [ADDR_W-1:0]  tag_q;
    logic [EPOCH_W-1:0] open_q, close_q;
    logic               sel, load_en, close_en;

    assign sel      = ev_hit ? (ev_idx == IDX_W'(i)) : (have_free && (free_idx == IDX_W'(i)));
    assign load_en  = is_wr && sel;
    assign close_en = !load_en && is_fn && used_q && flushed_q && !closed_q;

    always_comb begin
      used_d    = used_q;
      flushed_d = flushed_q;
      closed_d  = closed_q;
      if (load_en) begin
        used_d    = 1'b1;
        flushed_d = 1'b0;
        closed_d  = 1'b0;
      end else if (is_wb && ev_hit && (ev_idx == IDX_W'(i)) && !closed_q) begin
        flushed_d = 1'b1;
      end else if (close_en) begin
        closed_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used_q    <= 1'b0;
        flushed_q <= 1'b0;
        closed_q  <= 1'b0;
      end else begin
        used_q    <= used_d;
        flushed_q <= flushed_d;
        closed_q  <= closed_d;
      end
    end

    always_ff @(posedge clk) begin
      if (load_en) begin
        tag_q  <= ev_addr_i;
        open_q <= epoch_i;
      end
      if (close_en) close_q <= epoch_i;
    end

    assign used_o[i]     = used_q;
    assign tags_o[i]     = tag_q;
    assign closed_o[i]   = closed_q;
    assign open_ep_o[i]  = open_q;
    assign close_ep_o[i] = close_q;

    // R6: a window closes only after its writeback
    assert_closed_after_wback_R6: assert property (@(posedge clk) disable iff (!rst_n)
      closed_q |-> flushed_q);
  end

  always_comb begin
    ovf_d = ovf_q;
    if (is_wr && !ev_hit && !have_free) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign overflow_o = ovf_q;

  assert_no_overflow_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
endmodule

// File: rtl/persist_order_checker.sv
module persist_order_checker
  import pochk_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 32,
  parameter int EPOCH_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [1:0]        ev_op,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              q_valid,
  output logic              q_ready,
  input  logic              q_kind,
  input  logic [ADDR_W-1:0] q_addr_a,
  input  logic [ADDR_W-1:0] q_addr_b,
  output logic              r_valid,
  output logic              r_pass,
  output logic              r_violation,
  output logic              r_miss,
  output logic              overflow
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ev_op_e                        op;
  logic [EPOCH_W-1:0]            epoch;
  logic [DEPTH-1:0]              used;
  logic [DEPTH-1:0][ADDR_W-1:0]  tags;
  logic [DEPTH-1:0]              closed;
  logic [DEPTH-1:0][EPOCH_W-1:0] open_ep, close_ep;
  logic                          hit_a, hit_b;
  logic [IDX_W-1:0]              idx_a, idx_b;
  logic                          pass_d, miss_d, viol_d;
  logic                          rv_q, pass_q, miss_q, viol_q;
  logic                          accept;

  assign op      = ev_op_e'(ev_op);
  assign q_ready = 1'b1;
  assign accept  = q_valid && q_ready;

  pochk_epoch #(.EPOCH_W(EPOCH_W)) i_epoch (
    .clk     (clk),
    .rst_n   (rst_n),
    .fence_i (ev_valid && (op == OP_FENCE)),
    .epoch_o (epoch)
  );

  pochk_table #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .EPOCH_W(EPOCH_W)) i_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid_i (ev_valid),
    .ev_op_i    (op),
    .ev_addr_i  (ev_addr),
    .epoch_i    (epoch),
    .used_o     (used),
    .tags_o     (tags),
    .closed_o   (closed),
    .open_ep_o  (open_ep),
    .close_ep_o (close_ep),
    .overflow_o (overflow)
  );

  pochk_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_match_a (
    .clk (clk), .rst_n (rst_n), .used_i (used), .tags_i (tags),
    .addr_i (q_addr_a), .hit_o (hit_a), .idx_o (idx_a)
  );

  pochk_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_match_b (
    .clk (clk), .rst_n (rst_n), .used_i (used), .tags_i (tags),
    .addr_i (q_addr_b), .hit_o (hit_b), .idx_o (idx_b)
  );

  always_comb begin
    if (q_kind_e'(q_kind) == Q_DURABLE) begin
      miss_d = !hit_a;
      pass_d = hit_a && closed[idx_a];
    end else begin
      miss_d = !hit_a || !hit_b;
      pass_d = !miss_d && closed[idx_a] && (close_ep[idx_a] < open_ep[idx_b]);
    end
    viol_d = !miss_d && !pass_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pass_q <= pass_d;
      miss_q <= miss_d;
      viol_q <= viol_d;
    end
  end

  assign r_valid     = rv_q;
  assign r_pass      = pass_q;
  assign r_miss      = miss_q;
  assign r_violation = viol_q;

  assert_resp_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> r_valid);
  assert_resp_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> !r_valid);
  assert_miss_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_miss) |-> (!r_pass && !r_violation));
  assert_one_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> ($countones({r_pass, r_violation, r_miss}) == 1));
endmodule

// File: tb/test_persist_order_checker.sv
`timescale 1ns/1ps
module test_persist_order_checker;
  localparam int AW = 32;
  localparam time CLK_PERIOD = 20ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ev_valid;
  logic [1:0]    ev_op;
  logic [AW-1:0] ev_addr;
  logic          q_valid, q_ready, q_kind;
  logic [AW-1:0] q_addr_a, q_addr_b;
  logic          r_valid, r_pass, r_violation, r_miss, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  persist_order_checker i_persist_order_checker (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_op(ev_op), .ev_addr(ev_addr),
    .q_valid(q_valid), .q_ready(q_ready), .q_kind(q_kind),
    .q_addr_a(q_addr_a), .q_addr_b(q_addr_b), .r_valid(r_valid), .r_pass(r_pass),
    .r_violation(r_violation), .r_miss(r_miss), .overflow(overflow)
  );

  // step kind: 0 store, 1 writeback, 2 fence, 3 ordering query, 4 durability query
  // fields: kind[20:18] a[17:10] b[9:2] exp_pass[1] exp_miss[0]
  localparam int NV = 23;
  localparam logic [20:0] VEC [NV] = '{
    {3'd0, 8'h10, 8'h00, 1'b0, 1'b0},
    {3'd4, 8'h10, 8'h00, 1'b0, 1'b0},
    {3'd2, 8'h00, 8'h00, 1'b0, 1'b0},
    {3'd4, 8'h10, 8'h00, 1'b0, 1'b0},
    {3'd1, 8'h10, 8'h00, 1'b0, 1'b0},
    {3'd4, 8'h10, 8'h00, 1'b0, 1'b0},
    {3'd2, 8'h00, 8'h00, 1'b0, 1'b0},
    {3'd4, 8'h10, 8'h00, 1'b1, 1'b0},
    {3'd0, 8'h20, 8'h00, 1'b0, 1'b0},
    {3'd3, 8'h10, 8'h20, 1'b1, 1'b0},
    {3'd0, 8'h30, 8'h00, 1'b0, 1'b0},
    {3'd1, 8'h30, 8'h00, 1'b0, 1'b0},
    {3'd0, 8'h40, 8'h00, 1'b0, 1'b0},
    {3'd2, 8'h00, 8'h00, 1'b0, 1'b0},
    {3'd3, 8'h30, 8'h40, 1'b0, 1'b0},
    {3'd3, 8'h20, 8'h30, 1'b0, 1'b0},
    {3'd3, 8'h10, 8'h55, 1'b0, 1'b1},
    {3'd1, 8'h66, 8'h00, 1'b0, 1'b0},
    {3'd0, 8'h66, 8'h00, 1'b0, 1'b0},
    {3'd2, 8'h00, 8'h00, 1'b0, 1'b0},
    {3'd4, 8'h66, 8'h00, 1'b0, 1'b0},
    {3'd0, 8'h10, 8'h00, 1'b0, 1'b0},
    {3'd4, 8'h10, 8'h00, 1'b0, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      1, 5:     return "R2";
      3, 7:     return "R6";
      9:        return "R4";
      14, 15:   return "R5";
      16:       return "R9";
      20:       return "R8";
      22:       return "R7";
      default:  return "R2";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_event(logic [1:0] op, logic [AW-1:0] a);
    @(negedge clk);
    ev_valid = 1'b1; ev_op = op; ev_addr = a;
    @(negedge clk);
    ev_valid = 1'b0; ev_op = 2'd3;
  endtask

  task automatic do_query(string tag, logic kind, logic [AW-1:0] a, logic [AW-1:0] b,
                          logic exp_pass, logic exp_miss);
    @(negedge clk);
    q_valid = 1'b1; q_kind = kind; q_addr_a = a; q_addr_b = b;
    @(negedge clk);
    q_valid = 1'b0;
    check(tag, "r_valid", 32'(r_valid), 32'd1);
    check(tag, "pass/viol/miss", {29'd0, r_pass, r_violation, r_miss},
          {29'd0, exp_pass, !exp_pass && !exp_miss, exp_miss});
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev_valid = 1'b0; ev_op = 2'd3; ev_addr = '0;
    q_valid = 1'b0; q_kind = 1'b0; q_addr_a = '0; q_addr_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "r_valid", 32'(r_valid), 32'd0);
    check("R1", "overflow", 32'(overflow), 32'd0);
    check("R1", "q_ready", 32'(q_ready), 32'd1);
    do_query("R1", 1'b1, 32'h10, 32'h0, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] k;
      k = VEC[i][20:18];
      if (k < 3'd3)
        do_event(k[1:0], {24'd0, VEC[i][17:10]});
      else
        do_query(vec_tag(i), (k == 3'd4), {24'd0, VEC[i][17:10]}, {24'd0, VEC[i][9:2]},
                 VEC[i][1], VEC[i][0]);
    end

    // R10: result lasts one cycle only
    @(negedge clk);
    check("R10", "r_valid idle", 32'(r_valid), 32'd0);
    // R10: same-cycle event is not seen by the query (0x77 untracked before)
    @(negedge clk);
    ev_valid = 1'b1; ev_op = 2'd0; ev_addr = 32'h77;
    q_valid = 1'b1; q_kind = 1'b1; q_addr_a = 32'h77;
    @(negedge clk);
    ev_valid = 1'b0; ev_op = 2'd3; q_valid = 1'b0;
    check("R10", "same-cycle miss", 32'(r_miss), 32'd1);

    // six entries used (10,20,30,40,66,77): fill the rest
    do_event(2'd0, 32'h70);
    do_event(2'd0, 32'h71);
    // R7: rewrite while full takes no new slot
    do_event(2'd0, 32'h20);
    check("R7", "overflow after rewrite", 32'(overflow), 32'd0);
    // R3: new address while full
    do_event(2'd0, 32'h80);
    check("R3", "overflow set", 32'(overflow), 32'd1);
    do_query("R3", 1'b1, 32'h80, 32'h0, 1'b0, 1'b1);
    do_event(2'd2, 32'h0);
    check("R3", "overflow sticky", 32'(overflow), 32'd1);

    // R1: reset mid-run clears state
    apply_reset();
    @(negedge clk);
    check("R1", "overflow after reset", 32'(overflow), 32'd0);
    do_query("R1", 1'b1, 32'h10, 32'h0, 1'b0, 1'b1);

    // R4: fresh reset, clean disjoint pair
    do_event(2'd0, 32'hA0);
    do_event(2'd1, 32'hA0);
    do_event(2'd2, 32'h0);
    do_event(2'd0, 32'hB0);
    do_query("R4", 1'b0, 32'hA0, 32'hB0, 1'b1, 1'b0);
    // R5: reversed pair, B not closed
    do_query("R5", 1'b0, 32'hB0, 32'hA0, 1'b0, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule